// File: doc/BRIEF.md
# Event Flag and Routing Control

This block sits between a low-rate counting/compare engine and the rest of the chip. The engine raises six one-cycle event pulses: a counter tick, a counter wrap, and four compare matches. Every source owns a sticky status flag, a routing enable and an interrupt enable. A source whose routing enable and interrupt enable are both clear is gated off at the input. It sets no flag, drives no output and costs nothing downstream. A source with routing enabled is forwarded as a one-cycle pulse on its own output line. The single interrupt line is high while any flag is set together with its interrupt enable.

Software reaches the block through a flat word-addressed bus with a write strobe and a combinational read. The routing mask can be written directly, or one bit at a time through a write-1-to-set alias and a write-1-to-clear alias. The interrupt mask has only the set and clear aliases. Every mask view uses the same bit layout and reads back the current mask. At the default parameters the map is as follows. The status flags are at word addresses 0 to 5, in the order tick, wrap, compare 0, compare 1, compare 2, compare 3. The routing mask is at 8 for direct access, 9 for set and 10 for clear. The interrupt mask is at 12 for set and 13 for clear. The `raw_evt` and `evt_out` vectors use the same source order as the flag addresses.

Top module: `evt_route_ctl`

## Requirements
- R1: After reset, both masks and all six flags are 0, `evt_out` is 0, `irq` is 0 and every address reads 0.
- R2: In every mask view, bit 0 is tick, bit 1 is wrap and bits 16 to 19 are compare 0 to compare 3. All other bits read 0 and ignore writes.
- R3: A write to address 8 replaces the routing mask. Addresses 8, 9 and 10 all read back the current routing mask.
- R4: A write to a set alias (9 for routing, 12 for interrupt) sets each mask bit whose data bit is 1 and leaves the others unchanged. Addresses 12 and 13 both read back the interrupt mask.
- R5: A write to a clear alias (10 for routing, 13 for interrupt) clears each mask bit whose data bit is 1 and leaves the others unchanged.
- R6: A raw event whose routing bit and interrupt bit are both 0 sets no flag and produces no output pulse.
- R7: A raw event whose routing bit or interrupt bit is 1 sets its flag from the next cycle on. Flag s reads at address s in data bit 0.
- R8: `evt_out[s]` is high for exactly the one cycle after `raw_evt[s]` was high with routing bit s set. The interrupt bit alone never produces a pulse.
- R9: `irq` is the OR, over all sources, of flag AND interrupt enable.
- R10: A write to a flag address stores data bit 0, so writing 0 clears the flag. An accepted event in the same cycle wins and leaves the flag at 1.
- R11: Gating and routing in a cycle use the mask values from before any mask write in that same cycle.
- R12: Unmapped addresses (6, 7, 11, 14, 15) read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_evt | input | 6 | Raw event pulses from the counting and compare logic |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_out | output | 6 | Routed event pulses, one cycle each |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets a flag write that lands in the same cycle as the event that sets that flag. A design that gives software priority would lose the event and leave the flag at 0. It also writes a mask in the same cycle that an event arrives. A design that gates on the new mask would drop or invent a pulse on `evt_out`. It drives the set and clear aliases with sparse data words to catch designs that load the word instead of merging it, which would wipe the other enables. It checks that the reserved bits read 0, since a misplaced compare field would show up on the wrong lane. Random traffic over the whole address space, including the unmapped holes, is compared every cycle against a bench model of the flags and masks.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

  // Number of non-compare sources (tick, wrap) ahead of the compare sources.
  localparam int unsigned FIXED_SRC = 2;

  // Position of a source's bit in the shared mask layout.
  function automatic int unsigned layout_pos(input int unsigned src,
                                             input int unsigned cmp_base);
    return (src < FIXED_SRC) ? src : cmp_base + (src - FIXED_SRC);
  endfunction

  // Size of the flag address window: next power of two above the source count.
  function automatic int unsigned flag_span(input int unsigned n_src);
    int unsigned span;
    span = 1;
    while (span < n_src) span = span * 2;
    return span;
  endfunction

  // Next mask value from a direct write, set alias or clear alias.
  function automatic logic [7:0] merge_mask(input logic [7:0] cur,
                                            input logic [7:0] bits,
                                            input logic wr_all,
                                            input logic wr_set,
                                            input logic wr_clr);
    if (wr_all)      return bits;
    else if (wr_set) return cur | bits;
    else if (wr_clr) return cur & ~bits;
    return cur;
  endfunction

endpackage

// File: rtl/evt_route_mask.sv
module evt_route_mask
  import evt_route_pkg::*;
#(
  parameter int unsigned N_SRC    = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CMP_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_all,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [N_SRC-1:0]  wbits,
  output logic [N_SRC-1:0]  mask_q,
  output logic [DATA_W-1:0] view
);

  logic [7:0] cur_w;
  logic [7:0] bits_w;
  logic [7:0] nxt_w;

  assign cur_w  = 8'(mask_q);
  assign bits_w = 8'(wbits);
  assign nxt_w  = merge_mask(cur_w, bits_w, wr_all, wr_set, wr_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= nxt_w[N_SRC-1:0];
  end

  always_comb begin
    view = '0;
    for (int s = 0; s < N_SRC; s++)
      view = view | (DATA_W'(mask_q[s]) << layout_pos(s, CMP_BASE));
  end

  logic unused_hi;
  assign unused_hi = ^nxt_w;

endmodule

// File: rtl/evt_route_flag.sv
module evt_route_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic route_en,
  input  logic int_en,
  input  logic sw_wr,
  input  logic sw_val,
  output logic taken,
  output logic flag_q,
  output logic pulse_q
);

  // An event is accepted only if some consumer is enabled for it.
  assign taken = raw & (route_en | int_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (taken)      flag_q <= 1'b1;
      else if (sw_wr) flag_q <= sw_val;
      pulse_q <= raw & route_en;
    end
  end

endmodule

// File: rtl/evt_route_ctl.sv
module evt_route_ctl
  import evt_route_pkg::*;
#(
  parameter int unsigned N_CMP    = 4,
  parameter int unsigned CMP_BASE = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  localparam int unsigned N_SRC   = FIXED_SRC + N_CMP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  raw_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_SRC-1:0]  evt_out,
  output logic              irq
);

  localparam int unsigned SPAN      = flag_span(N_SRC);
  localparam int unsigned A_ROUTE   = SPAN;
  localparam int unsigned A_RSET    = SPAN + 1;
  localparam int unsigned A_RCLR    = SPAN + 2;
  localparam int unsigned A_ISET    = SPAN + 4;
  localparam int unsigned A_ICLR    = SPAN + 5;

  // Named internal events, visible to the bound checker.
  logic [N_SRC-1:0] wbits;
  logic [N_SRC-1:0] route_q;
  logic [N_SRC-1:0] int_q;
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] ev_taken;
  logic [N_SRC-1:0] flag_wr;
  logic [N_SRC-1:0] flag_wr_one;
  logic             route_all_wr;
  logic             route_set_wr;
  logic             route_clr_wr;
  logic             int_set_wr;
  logic             int_clr_wr;
  logic [DATA_W-1:0] route_view;
  logic [DATA_W-1:0] int_view;

  // Compact the write word into source order.
  for (genvar s = 0; s < N_SRC; s++) begin : g_pack
    localparam int unsigned POS = layout_pos(s, CMP_BASE);
    assign wbits[s] = reg_wdata[POS];
  end

  assign route_all_wr = reg_we && (reg_addr == ADDR_W'(A_ROUTE));
  assign route_set_wr = reg_we && (reg_addr == ADDR_W'(A_RSET));
  assign route_clr_wr = reg_we && (reg_addr == ADDR_W'(A_RCLR));
  assign int_set_wr   = reg_we && (reg_addr == ADDR_W'(A_ISET));
  assign int_clr_wr   = reg_we && (reg_addr == ADDR_W'(A_ICLR));

  evt_route_mask #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .CMP_BASE(CMP_BASE)
  ) u_route_mask (
    .clk(clk), .rst_n(rst_n),
    .wr_all(route_all_wr), .wr_set(route_set_wr), .wr_clr(route_clr_wr),
    .wbits(wbits), .mask_q(route_q), .view(route_view)
  );

  evt_route_mask #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .CMP_BASE(CMP_BASE)
  ) u_int_mask (
    .clk(clk), .rst_n(rst_n),
    .wr_all(1'b0), .wr_set(int_set_wr), .wr_clr(int_clr_wr),
    .wbits(wbits), .mask_q(int_q), .view(int_view)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign flag_wr[s]     = reg_we && (reg_addr == ADDR_W'(s));
    assign flag_wr_one[s] = flag_wr[s] & reg_wdata[0];

    evt_route_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .raw(raw_evt[s]), .route_en(route_q[s]), .int_en(int_q[s]),
      .sw_wr(flag_wr[s]), .sw_val(reg_wdata[0]),
      .taken(ev_taken[s]), .flag_q(flag_q[s]), .pulse_q(evt_out[s])
    );
  end

  assign irq = |(flag_q & int_q);

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < N_SRC; s++)
      if (reg_addr == ADDR_W'(s)) reg_rdata = DATA_W'(flag_q[s]);
    if (reg_addr == ADDR_W'(A_ROUTE) || reg_addr == ADDR_W'(A_RSET) ||
        reg_addr == ADDR_W'(A_RCLR))
      reg_rdata = route_view;
    if (reg_addr == ADDR_W'(A_ISET) || reg_addr == ADDR_W'(A_ICLR))
      reg_rdata = int_view;
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

endmodule

// File: rtl/evt_route_chk.sv
module evt_route_chk
  import evt_route_pkg::*;
#(
  parameter int unsigned N_SRC    = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CMP_BASE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  raw_evt,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [N_SRC-1:0]  evt_out,
  input logic              irq,
  input logic [N_SRC-1:0]  route_q,
  input logic [N_SRC-1:0]  int_q,
  input logic [N_SRC-1:0]  flag_q,
  input logic [N_SRC-1:0]  flag_wr,
  input logic [N_SRC-1:0]  flag_wr_one,
  input logic [N_SRC-1:0]  wbits,
  input logic              int_set_wr,
  input logic              route_clr_wr
);

  logic [DATA_W-1:0] layout;
  always_comb begin
    layout = '0;
    for (int s = 0; s < N_SRC; s++)
      layout = layout | (DATA_W'(1) << layout_pos(s, CMP_BASE));
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~layout) == '0); // R2

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    int_set_wr |=> ((int_q & $past(wbits)) == $past(wbits))); // R4

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    route_clr_wr |=> ((route_q & $past(wbits)) == '0)); // R5

  AST_GATED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) &
               ~$past(raw_evt & (route_q | int_q)) & ~$past(flag_wr_one)) == '0)); // R6

  AST_PULSE_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_out & ~$past(raw_evt & route_q)) == '0)); // R8

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_q != '0)); // R9

  AST_FLAG_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(flag_wr)) == '0)); // R10

endmodule

bind evt_route_ctl evt_route_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .CMP_BASE(CMP_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_evt(raw_evt), .reg_rdata(reg_rdata),
  .evt_out(evt_out), .irq(irq), .route_q(route_q), .int_q(int_q),
  .flag_q(flag_q), .flag_wr(flag_wr), .flag_wr_one(flag_wr_one),
  .wbits(wbits), .int_set_wr(int_set_wr), .route_clr_wr(route_clr_wr)
);

// File: tb/evt_route_ctl_bench.sv
module evt_route_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  raw_evt = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  evt_out;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model
  logic [5:0] m_route = '0;
  logic [5:0] m_int = '0;
  logic [5:0] m_flag = '0;
  logic [5:0] m_pulse = '0;

  always #4 clk = ~clk;

  evt_route_ctl u_evt_route_ctl (
    .clk(clk), .rst_n(rst_n), .raw_evt(raw_evt), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_out(evt_out), .irq(irq)
  );

  function automatic logic [31:0] tb_spread(input logic [5:0] m);
    return {12'h000, m[5:2], 14'h0000, m[1:0]};
  endfunction

  function automatic logic [5:0] tb_gather(input logic [31:0] w);
    return {w[19:16], w[1:0]};
  endfunction

  function automatic logic [31:0] tb_read(input logic [3:0] a);
    if (a < 4'd6)                 return {31'd0, m_flag[a[2:0]]};
    if (a >= 4'd8 && a <= 4'd10)  return tb_spread(m_route);
    if (a == 4'd12 || a == 4'd13) return tb_spread(m_int);
    return 32'd0;
  endfunction

  function automatic string tb_tag(input logic [3:0] a);
    if (a < 4'd6)                 return "R7";
    if (a >= 4'd8 && a <= 4'd10)  return "R3";
    if (a == 4'd12 || a == 4'd13) return "R4";
    return "R12";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus/event cycle; starts and ends at a falling edge.
  task automatic cyc(input logic [5:0] raw, input logic we, input logic [3:0] a,
                     input logic [31:0] d);
    logic [5:0] bits;
    raw_evt = raw; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    bits = tb_gather(d);
    m_pulse = raw & m_route;
    for (int s = 0; s < 6; s++) begin
      if (raw[s] && (m_route[s] || m_int[s])) m_flag[s] = 1'b1;
      else if (we && a == 4'(s))              m_flag[s] = d[0];
    end
    if (we) begin
      case (a)
        4'd8:  m_route = bits;
        4'd9:  m_route = m_route | bits;
        4'd10: m_route = m_route & ~bits;
        4'd12: m_int = m_int | bits;
        4'd13: m_int = m_int & ~bits;
        default: ;
      endcase
    end
    @(negedge clk);
    check("R8", 32'(evt_out), 32'(m_pulse));
    check("R9", 32'(irq), 32'(|(m_flag & m_int)));
    check(tb_tag(a), reg_rdata, tb_read(a));
    raw_evt = '0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string req, input logic [31:0] exp);
    reg_we = 1'b0; raw_evt = '0; reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", 32'(evt_out), 32'd0);
    check("R1", 32'(irq), 32'd0);
    for (int a = 0; a < 16; a++) rd(4'(a), "R1", 32'd0);

    // R6: no enables -> gated
    cyc(6'h3F, 1'b0, 4'd0, 32'd0);
    for (int a = 0; a < 6; a++) rd(4'(a), "R6", 32'd0);

    // R2 and R3: direct write of all ones
    cyc(6'h00, 1'b1, 4'd8, 32'hFFFF_FFFF);
    rd(4'd8, "R2", 32'h000F_0003);
    rd(4'd9, "R3", 32'h000F_0003);
    rd(4'd10, "R3", 32'h000F_0003);

    // R8: routed pulse one cycle, then gone
    cyc(6'h3F, 1'b0, 4'd0, 32'd0);
    check("R8", 32'(evt_out), 32'h3F);
    cyc(6'h00, 1'b0, 4'd0, 32'd0);
    check("R8", 32'(evt_out), 32'h00);
    for (int a = 0; a < 6; a++) rd(4'(a), "R7", 32'd1);
    check("R9", 32'(irq), 32'd0);

    // R10: software clear, and event beats a same-cycle clear
    cyc(6'h00, 1'b1, 4'd2, 32'd0);
    rd(4'd2, "R10", 32'd0);
    cyc(6'h01, 1'b1, 4'd0, 32'd0);
    rd(4'd0, "R10", 32'd1);

    // R5: clear alias with sparse data
    cyc(6'h00, 1'b1, 4'd10, 32'h0001_0001);
    rd(4'd8, "R5", 32'h000E_0002);

    // R4: set alias on interrupt mask, irq from compare 1 flag
    cyc(6'h00, 1'b1, 4'd12, 32'h0002_0002);
    rd(4'd12, "R4", 32'h0002_0002);
    rd(4'd13, "R4", 32'h0002_0002);
    check("R9", 32'(irq), 32'd1);
    cyc(6'h00, 1'b1, 4'd3, 32'd0);
    check("R9", 32'(irq), 32'd1);
    cyc(6'h00, 1'b1, 4'd1, 32'd0);
    check("R9", 32'(irq), 32'd0);

    // R11: clear routing of wrap in the same cycle as a wrap event
    cyc(6'h02, 1'b1, 4'd10, 32'h0000_0002);
    check("R11", 32'(evt_out), 32'h02);
    rd(4'd1, "R11", 32'd1);

    // R12: writes to holes change nothing
    cyc(6'h00, 1'b1, 4'd7, 32'hFFFF_FFFF);
    cyc(6'h00, 1'b1, 4'd15, 32'hFFFF_FFFF);
    rd(4'd7, "R12", 32'd0);
    rd(4'd8, "R12", tb_spread(m_route));
    rd(4'd12, "R12", tb_spread(m_int));

    // Random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [5:0] r;
      r = 6'($urandom) & 6'($urandom);
      cyc(r, ($urandom % 3) == 0, 4'($urandom), $urandom);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule